// File: doc/BRIEF.md
# Peripheral Port Region Override Decoder

This block holds one programmable address window and checks every data access against it. A data access whose physical address falls inside the window is sent to a peripheral port. Its memory type is forced to non-shared device, whatever attribute the page tables or the general data remap produced. The window has a size code and a base address. The base is assumed to be aligned to the window size, so base bits below the window size are left out of the comparison.

Software programs the window through a small register port. Only privileged accesses that use select code 4 reach the register. A user-mode access raises an undefined-instruction indication instead. Two other rules apply on the lookup side. A tightly-coupled memory (TCM) in normal mode takes priority over the window. A TCM running as a cache gives way to the window. Unaligned or exclusive accesses that hit the window raise an error flag, because device memory cannot serve them. The lookup path is combinational. A register write takes effect from the next clock cycle.

Top module: `pport_region_decoder`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0 and no access selects the peripheral port.
- R2: In the register, bits [31:12] are the base and bits [4:0] are the size code, and bits [11:5] always read 0. A privileged write with cfg_sel = 4 stores the value, and a read with the same select returns it from the next cycle on.
- R3: Any cfg_en access with cfg_priv = 0 drives cfg_undef high and cfg_rdata to 0, and it leaves the register unchanged.
- R4: An access with a select code other than 4 neither writes the register nor returns its contents: cfg_rdata is 0.
- R5: Size codes 0, 1, 2 and 23 to 31 disable the window, so no address matches.
- R6: A size code c from 3 to 22 gives a window of 2^(c+9) bytes. An address matches when its bits [31:c+9] equal the same bits of the base. Base bits below c+9 are ignored.
- R7: Only a valid data access can match. acc_kind uses 0 for data, 1 for instruction fetch, 2 for DMA and 3 reserved, and codes 1 to 3 never match. An access with acc_valid = 0 never matches.
- R8: A matching access with tcm_hit = 1 and tcm_cache_mode = 0 does not select the peripheral port.
- R9: A matching access with tcm_hit = 1 and tcm_cache_mode = 1 selects the peripheral port.
- R10: When pport_sel is 1, attr_out is 3'b011 (device) and shared_out is 0. Otherwise attr_out and shared_out equal attr_in and shared_in.
- R11: pport_err is 1 exactly when pport_sel is 1 and the access is unaligned or exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 3 | Register select code; 4 addresses this block |
| cfg_priv | input | 1 | Access is privileged |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| cfg_undef | output | 1 | User-mode access attempted |
| acc_valid | input | 1 | Lookup access present |
| acc_addr | input | 32 | Physical address of the access |
| acc_kind | input | 2 | 0 data, 1 instruction, 2 DMA, 3 reserved |
| acc_unaligned | input | 1 | Access is unaligned |
| acc_excl | input | 1 | Access is exclusive |
| tcm_hit | input | 1 | Address lies inside a TCM |
| tcm_cache_mode | input | 1 | The hit TCM runs as a cache |
| attr_in | input | 3 | Memory type after page tables and data remap |
| shared_in | input | 1 | Shared bit after page tables and data remap |
| pport_sel | output | 1 | Route the access to the peripheral port |
| attr_out | output | 3 | Final memory type |
| shared_out | output | 1 | Final shared bit |
| pport_err | output | 1 | Unsupported access kind hit the window |

## Verification
The hardest case to reach from the ports is the edge of the alignment mask at each size. The bench has to show that the lowest compared bit moves by exactly one position per size code, and that garbage in the ignored base bits has no effect. The bench covers this by sweeping all 32 size codes over several base patterns, each carrying noise in its low bits. For each setting it probes the first byte of the window, the last byte, the byte just past the end and the byte just below the start. The expected result is worked out by shifting the address and the base by the size exponent.

// File: rtl/pport_pkg.sv
// Package: shared encodings for the peripheral port region decoder.
// Assumes a 32-bit register layout with the base in the upper bits and size in the low bits.
package pport_pkg;
    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_INSTR = 2'd1,
        ACC_DMA   = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [2:0] ATTR_DEVICE = 3'b011;
endpackage

// File: rtl/pport_cfg_reg.sv
// Module: holds the base/size register and serves privileged reads and writes.
// Assumes the access strobe is a single-cycle pulse; reads are combinational.
module pport_cfg_reg #(
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 3,
    parameter int MY_SEL    = 4,
    parameter int BASE_LSB  = 12,
    parameter int SIZE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_priv,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_undef,
    output logic [DATA_W-1:0] cfg_q
);
    localparam int HOLE_W = BASE_LSB - SIZE_W;
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{(DATA_W-BASE_LSB){1'b1}}, {HOLE_W{1'b0}}, {SIZE_W{1'b1}}};

    logic addr_hit;
    logic wr_ok;

    // Decode whether this access targets the register with sufficient privilege.
    always_comb begin
        addr_hit  = (cfg_sel == SEL_W'(MY_SEL));
        wr_ok     = cfg_en && cfg_wr && cfg_priv && addr_hit;
        cfg_undef = cfg_en && !cfg_priv;
    end

    // Store the written value with the reserved hole cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_ok)
            cfg_q <= cfg_wdata & KEEP_MASK;
    end

    // Return the register only for a privileged read of this select.
    always_comb begin
        if (cfg_en && !cfg_wr && cfg_priv && addr_hit)
            cfg_rdata = cfg_q;
        else
            cfg_rdata = '0;
    end
endmodule

// File: rtl/pport_region_match.sv
// Module: compares an address against a size-encoded, alignment-masked window.
// Assumes size code c selects 2^(c+SIZE_OFS) bytes for SIZE_MIN <= c <= SIZE_MAX.
module pport_region_match #(
    parameter int ADDR_W   = 32,
    parameter int BASE_LSB = 12,
    parameter int SIZE_W   = 5,
    parameter int SIZE_MIN = 3,
    parameter int SIZE_MAX = 22,
    parameter int SIZE_OFS = 9
) (
    input  logic [ADDR_W-1:BASE_LSB] addr_hi,
    input  logic [ADDR_W-1:BASE_LSB] base_hi,
    input  logic [SIZE_W-1:0]        size_code,
    output logic                     in_window
);
    logic                     code_ok;
    logic [ADDR_W-1:BASE_LSB] diff;
    int                       low_bit;

    // Classify the size code and derive the lowest compared bit.
    always_comb begin
        code_ok = (int'(size_code) >= SIZE_MIN) && (int'(size_code) <= SIZE_MAX);
        low_bit = int'(size_code) + SIZE_OFS;
    end

    // One comparator per upper address bit, masked below the window size.
    for (genvar i = BASE_LSB; i < ADDR_W; i++) begin : g_bit
        assign diff[i] = (i >= low_bit) && (addr_hi[i] != base_hi[i]);
    end

    // The window matches when the code is usable and no compared bit differs.
    always_comb in_window = code_ok && (diff == '0);
endmodule

// File: rtl/pport_route.sv
// Module: applies access-kind and TCM priority rules, forces the attribute, flags errors.
// Assumes attr_in/shared_in already include any general data remap.
module pport_route
    import pport_pkg::*;
(
    input  logic      in_window,
    input  logic      acc_valid,
    input  acc_kind_e kind,
    input  logic      acc_unaligned,
    input  logic      acc_excl,
    input  logic      tcm_hit,
    input  logic      tcm_cache_mode,
    input  logic [2:0] attr_in,
    input  logic      shared_in,
    output logic      pport_sel,
    output logic [2:0] attr_out,
    output logic      shared_out,
    output logic      pport_err
);
    logic tcm_claims;

    // A TCM in normal mode keeps the access; a cache-mode TCM yields.
    always_comb tcm_claims = tcm_hit && !tcm_cache_mode;

    // Select the port for data accesses in the window not claimed by a TCM.
    always_comb pport_sel = acc_valid && (kind == ACC_DATA) && in_window && !tcm_claims;

    // Override the memory type for selected accesses and flag unsupported kinds.
    always_comb begin
        attr_out   = pport_sel ? ATTR_DEVICE : attr_in;
        shared_out = pport_sel ? 1'b0 : shared_in;
        pport_err  = pport_sel && (acc_unaligned || acc_excl);
    end
endmodule

// File: rtl/pport_region_decoder.sv
// Module: top of the peripheral port region override decoder.
// Assumes lookups are combinational and register writes apply from the next cycle.
module pport_region_decoder
    import pport_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEL_W    = 3,
    parameter int MY_SEL   = 4,
    parameter int BASE_LSB = 12,
    parameter int SIZE_W   = 5,
    parameter int SIZE_MIN = 3,
    parameter int SIZE_MAX = 22,
    parameter int SIZE_OFS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_priv,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              cfg_undef,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_unaligned,
    input  logic              acc_excl,
    input  logic              tcm_hit,
    input  logic              tcm_cache_mode,
    input  logic [2:0]        attr_in,
    input  logic              shared_in,
    output logic              pport_sel,
    output logic [2:0]        attr_out,
    output logic              shared_out,
    output logic              pport_err
);
    logic [ADDR_W-1:0] cfg_q;
    logic              in_window;
    logic              addr_lo_unused;

    // Low address bits never take part in the comparison.
    always_comb addr_lo_unused = ^acc_addr[BASE_LSB-1:0];

    pport_cfg_reg #(
        .DATA_W(ADDR_W), .SEL_W(SEL_W), .MY_SEL(MY_SEL),
        .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_undef(cfg_undef), .cfg_q(cfg_q)
    );

    pport_region_match #(
        .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W),
        .SIZE_MIN(SIZE_MIN), .SIZE_MAX(SIZE_MAX), .SIZE_OFS(SIZE_OFS)
    ) u_match (
        .addr_hi(acc_addr[ADDR_W-1:BASE_LSB]),
        .base_hi(cfg_q[ADDR_W-1:BASE_LSB]),
        .size_code(cfg_q[SIZE_W-1:0]),
        .in_window(in_window)
    );

    pport_route u_route (
        .in_window(in_window), .acc_valid(acc_valid),
        .kind(acc_kind_e'(acc_kind)),
        .acc_unaligned(acc_unaligned), .acc_excl(acc_excl),
        .tcm_hit(tcm_hit), .tcm_cache_mode(tcm_cache_mode),
        .attr_in(attr_in), .shared_in(shared_in),
        .pport_sel(pport_sel), .attr_out(attr_out),
        .shared_out(shared_out), .pport_err(pport_err)
    );
endmodule

// File: rtl/pport_region_decoder_chk.sv
// Module: property checker bound to the decoder top.
// Assumes it observes the stored register through the top's cfg_q.
module pport_region_decoder_chk #(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 5,
    parameter int SIZE_MIN = 3,
    parameter int SIZE_MAX = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              cfg_wr,
    input logic              cfg_priv,
    input logic              cfg_undef,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic [ADDR_W-1:0] cfg_q,
    input logic [1:0]        acc_kind,
    input logic              tcm_hit,
    input logic              tcm_cache_mode,
    input logic              pport_sel,
    input logic              pport_err,
    input logic [2:0]        attr_out,
    input logic              shared_out
);
    AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_priv) |-> (cfg_undef && cfg_rdata == '0)); // R3
    AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_wr && !cfg_priv) |=> $stable(cfg_q)); // R3
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(cfg_q[SIZE_W-1:0]) < SIZE_MIN) || (int'(cfg_q[SIZE_W-1:0]) > SIZE_MAX))
        |-> !pport_sel); // R5
    AST_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pport_sel |-> (acc_kind == 2'd0)); // R7
    AST_TCM_NORMAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tcm_hit && !tcm_cache_mode) |-> !pport_sel); // R8
    AST_OVERRIDE_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        pport_sel |-> (attr_out == 3'b011 && !shared_out)); // R10
    AST_ERR_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pport_err |-> pport_sel); // R11
endmodule

bind pport_region_decoder pport_region_decoder_chk #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SIZE_MIN(SIZE_MIN), .SIZE_MAX(SIZE_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_priv(cfg_priv), .cfg_undef(cfg_undef), .cfg_rdata(cfg_rdata),
    .cfg_q(cfg_q), .acc_kind(acc_kind), .tcm_hit(tcm_hit),
    .tcm_cache_mode(tcm_cache_mode), .pport_sel(pport_sel),
    .pport_err(pport_err), .attr_out(attr_out), .shared_out(shared_out)
);

// File: tb/pport_region_decoder_test.sv
`timescale 1ns/1ps
module pport_region_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0, cfg_priv = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_undef;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'd0;
    logic        acc_unaligned = 1'b0, acc_excl = 1'b0;
    logic        tcm_hit = 1'b0, tcm_cache_mode = 1'b0;
    logic [2:0]  attr_in = 3'd0;
    logic        shared_in = 1'b0;
    logic        pport_sel, shared_out, pport_err;
    logic [2:0]  attr_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pport_region_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_undef(cfg_undef), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_unaligned(acc_unaligned),
        .acc_excl(acc_excl), .tcm_hit(tcm_hit), .tcm_cache_mode(tcm_cache_mode),
        .attr_in(attr_in), .shared_in(shared_in), .pport_sel(pport_sel),
        .attr_out(attr_out), .shared_out(shared_out), .pport_err(pport_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [31:0] v, logic [2:0] sel, logic priv);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wr = 1'b1; cfg_sel = sel; cfg_priv = priv; cfg_wdata = v;
        #1;
        chk("R3 undef on write", 32'(cfg_undef), 32'(!priv));
        @(negedge clk);
        cfg_en = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(logic [2:0] sel, logic priv, output logic [31:0] v);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wr = 1'b0; cfg_sel = sel; cfg_priv = priv;
        #1;
        v = cfg_rdata;
        chk("R3 undef on read", 32'(cfg_undef), 32'(!priv));
        cfg_en = 1'b0;
    endtask

    function automatic bit exp_window(logic [31:0] base, int code, logic [31:0] a);
        if (code < 3 || code > 22) return 1'b0;
        return (a >> (code + 9)) == (base >> (code + 9));
    endfunction

    // Apply one data lookup and check routing and attribute.
    task automatic probe(string req, logic [31:0] a, bit exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = 2'd0;
        tcm_hit = 1'b0; acc_unaligned = 1'b0; acc_excl = 1'b0;
        attr_in = 3'b110; shared_in = 1'b1;
        #1;
        chk(req, 32'(pport_sel), 32'(exp));
        chk("R10 attr", 32'(attr_out), exp ? 32'd3 : 32'd6);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv, wv, rs, sz, base;
        logic [31:0] bases [3];
        logic [31:0] addrs [6];
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1 reset rdata", cfg_rdata, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        cfg_read(3'd4, 1'b1, rv);
        chk("R1 reset register", rv, 32'd0);
        probe("R1 no hit after reset", 32'h0000_0000, 1'b0);

        // R2/R3/R4: register access rules
        cfg_write(32'h1234_5FF5, 3'd4, 1'b1);
        cfg_read(3'd4, 1'b1, rv);
        chk("R2 readback hole zero", rv, 32'h1234_5015);
        cfg_write(32'hFFFF_FFFF, 3'd4, 1'b0);
        cfg_read(3'd4, 1'b0, rv);
        chk("R3 user read zero", rv, 32'd0);
        cfg_read(3'd4, 1'b1, rv);
        chk("R3 user write ignored", rv, 32'h1234_5015);
        for (int s = 0; s < 8; s++) begin
            if (s == 4) continue;
            cfg_write(32'hDEAD_B00F, 3'(s), 1'b1);
            cfg_read(3'(s), 1'b1, rv);
            chk("R4 other select reads zero", rv, 32'd0);
        end
        cfg_read(3'd4, 1'b1, rv);
        chk("R4 other select no write", rv, 32'h1234_5015);

        // R5/R6: every size code against several bases and edge addresses
        bases[0] = 32'h0000_0000;
        bases[1] = 32'h8765_4000;
        bases[2] = 32'hFFFF_F000;
        for (int code = 0; code < 32; code++) begin
            for (int b = 0; b < 3; b++) begin
                wv = bases[b] | 32'h0000_0FE0 | 32'(code);
                cfg_write(wv, 3'd4, 1'b1);
                cfg_read(3'd4, 1'b1, rv);
                chk("R2 sweep readback", rv, wv & 32'hFFFF_F01F);
                base = bases[b];
                if (code >= 3 && code <= 22) sz = 32'(64'd1 << (code + 9));
                else sz = 32'h0000_1000;
                rs = base & ~(sz - 32'd1);
                addrs[0] = rs;
                addrs[1] = rs + sz - 32'd1;
                addrs[2] = rs + sz;
                addrs[3] = rs - 32'd1;
                addrs[4] = base | 32'h0000_0ABC;
                addrs[5] = 32'h1234_5678;
                for (int k = 0; k < 6; k++)
                    probe((code >= 3 && code <= 22) ? "R6 window edge" : "R5 disabled code",
                          addrs[k], exp_window(base, code, addrs[k]));
            end
        end

        // R7-R11: access kind, TCM mode and error sweep on a 2MB window
        cfg_write(32'h4000_000C, 3'd4, 1'b1);
        for (int inr = 0; inr < 2; inr++)
        for (int kd = 0; kd < 4; kd++)
        for (int th = 0; th < 2; th++)
        for (int tm = 0; tm < 2; tm++)
        for (int ua = 0; ua < 2; ua++)
        for (int ex = 0; ex < 2; ex++) begin
            bit eh;
            @(negedge clk);
            acc_valid = 1'b1;
            acc_addr = (inr != 0) ? 32'h4001_0010 : 32'h4020_0000;
            acc_kind = 2'(kd); tcm_hit = 1'(th); tcm_cache_mode = 1'(tm);
            acc_unaligned = 1'(ua); acc_excl = 1'(ex);
            attr_in = 3'(kd * 2 + th); shared_in = 1'(ua ^ ex ^ 1);
            eh = (inr != 0) && (kd == 0) && !(th != 0 && tm == 0);
            #1;
            if (kd != 0)              chk("R7 non-data never routed", 32'(pport_sel), 32'(eh));
            else if (th != 0 && tm == 0) chk("R8 normal TCM wins", 32'(pport_sel), 32'(eh));
            else if (th != 0)         chk("R9 cache TCM yields", 32'(pport_sel), 32'(eh));
            else                      chk("R6 data window", 32'(pport_sel), 32'(eh));
            chk("R10 attr_out", 32'(attr_out), eh ? 32'd3 : 32'(kd * 2 + th));
            chk("R10 shared_out", 32'(shared_out), eh ? 32'd0 : 32'(ua ^ ex ^ 1));
            chk("R11 err flag", 32'(pport_err), 32'(eh && (ua != 0 || ex != 0)));
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'd0; tcm_hit = 1'b0; acc_addr = 32'h4001_0010;
        #1;
        chk("R7 invalid access ignored", 32'(pport_sel), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule